// File: doc/BRIEF.md
# Processor Status Register with Flag Arbitration

This block holds the eight-bit status word of a small accumulator processor. The word carries three bank-select bits for data memory, two bits that record why the core last woke or reset, and the three result flags of the arithmetic unit (zero, nibble carry and carry). Each cycle the block takes one instruction's worth of inputs: an optional bus write that targets the status word, per-flag update enables, the operands and operation code of the arithmetic unit, the bit shifted out by a rotate, and the system events from power control and the watchdog.

When one instruction both writes the status word and updates flags, the flag update wins. The bus value never reaches the three flag bits, and it never reaches the two power-state bits. Those two bits move only on power-on, watchdog clear, sleep entry and watchdog timeout. The block also turns the bank bits into a base address for direct accesses, and into the high address bit for indirect accesses.

Top module: `procstat_reg`

## Requirements
- R1: The status word has this layout: bit 7 indirect bank select, bits 6:5 direct bank number, bit 4 time-out, bit 3 power-down, bit 2 zero, bit 1 nibble carry, bit 0 carry. `dir_bank_o` equals bits 6:5. `dir_base_o` equals the bank number times 128. `ind_hi_o` equals bit 7.
- R2: While `por_n_i` is low, and in the first cycle after it rises, bits 7:5 read 0 and bits 4 and 3 read 1. Bits 2:0 are undefined until they are first written or updated.
- R3: With `wr_en_i` high, bits 7:5 take `wr_data_i[7:5]` at the next clock edge. When no flag update enable is high, bits 2:0 also take `wr_data_i[2:0]`.
- R4: Bus writes never change bits 4 and 3.
- R5: If any of `upd_z_i`, `upd_dc_i` or `upd_c_i` is high, the bus write to bits 2:0 is dropped. Each enabled flag takes the arithmetic value. Each flag that is not enabled keeps its value.
- R6: `op_i` is encoded as 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 pass A, 6 rotate, 7 pass A. For AND, OR and XOR the result combines A and B. For pass and rotate the result is A. Zero is 1 exactly when the 8-bit result is 0. For codes 2 to 5 and 7, the carry and nibble-carry values are 0.
- R7: For add, carry is the carry out of bit 7 of A+B, and nibble carry is the carry out of bit 3.
- R8: Subtract forms A + ~B + 1. Carry is 1 when A >= B (no borrow). Nibble carry is 1 when A[3:0] >= B[3:0].
- R9: For rotate (code 6), the carry value is `rot_bit_i`, the bit the datapath shifted out. Nibble carry is 0.
- R10: A watchdog timeout clears bit 4. A watchdog clear sets bits 4 and 3. Sleep entry sets bit 4 and clears bit 3.
- R11: Power-on overrides every other event. A timeout in the same cycle as a watchdog clear leaves bit 4 at 0 and bit 3 unchanged. Sleep in the same cycle as a watchdog clear leaves bit 3 at 0.
- R12: A bus write of 0 combined with a zero-flag update on a zero result yields bits 7:5 = 0, bits 4:3 unchanged, zero = 1, and nibble carry and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | The current instruction's destination is the status word |
| wr_data_i | input | 8 | Bus data for the status write |
| upd_z_i | input | 1 | The instruction updates zero |
| upd_dc_i | input | 1 | The instruction updates nibble carry |
| upd_c_i | input | 1 | The instruction updates carry |
| op_i | input | 3 | Arithmetic operation code |
| opa_i | input | 8 | Operand A |
| opb_i | input | 8 | Operand B |
| rot_bit_i | input | 1 | Bit shifted out by a rotate |
| wdt_clr_i | input | 1 | Watchdog clear event |
| sleep_i | input | 1 | Sleep entry event |
| wdt_to_i | input | 1 | Watchdog timeout event |
| status_o | output | 8 | Status word |
| dir_bank_o | output | 2 | Direct bank number |
| dir_base_o | output | 9 | Base address of the direct bank |
| ind_hi_o | output | 1 | High address bit for indirect accesses |

## Verification
Every piece of state sits in a register that drives `status_o`, so a wrong flag, bank bit or power-state bit appears on the ports one clock edge after the input that caused it. A wrong bank bit also shows at once on `dir_bank_o`, `dir_base_o` or `ind_hi_o`. A flag that leaks through from the bus, or that is overwritten when it should hold, stays wrong until that flag is next written or updated. The bench therefore compares the whole word after every instruction, so the error is seen in the same cycle it appears.

// File: rtl/procstat_pkg.sv
package procstat_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_IOR  = 3'd3,
    OP_XOR  = 3'd4,
    OP_PASS = 3'd5,
    OP_ROT  = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;

  localparam int ST_C   = 0;
  localparam int ST_DC  = 1;
  localparam int ST_Z   = 2;
  localparam int ST_PD  = 3;
  localparam int ST_TO  = 4;
  localparam int ST_RP0 = 5;
  localparam int ST_RP1 = 6;
  localparam int ST_IRP = 7;

endpackage

// File: rtl/procstat_flag_alu.sv
module procstat_flag_alu
  import procstat_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            rot_bit_i,
  output logic [DW-1:0]   res_o,
  output logic            z_o,
  output logic            dc_o,
  output logic            c_o
);

  // Returns {carry, nibble carry, result}
  function automatic logic [DW+1:0] add_f(input logic [DW-1:0] a,
                                          input logic [DW-1:0] b,
                                          input logic cin);
    logic [NIB:0] lo;
    logic [DW:0]  full;
    lo   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    return {full[DW], lo[NIB], full[DW-1:0]};
  endfunction

  logic [DW+1:0] sum_w;
  logic [DW+1:0] diff_w;

  assign sum_w  = add_f(a_i, b_i, 1'b0);
  assign diff_w = add_f(a_i, ~b_i, 1'b1);

  always_comb begin
    res_o = a_i;
    dc_o  = 1'b0;
    c_o   = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        res_o = sum_w[DW-1:0];
        dc_o  = sum_w[DW];
        c_o   = sum_w[DW+1];
      end
      OP_SUB: begin
        res_o = diff_w[DW-1:0];
        dc_o  = diff_w[DW];
        c_o   = diff_w[DW+1];
      end
      OP_AND:  res_o = a_i & b_i;
      OP_IOR:  res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_ROT:  c_o   = rot_bit_i;
      default: res_o = a_i;
    endcase
  end

  assign z_o = (res_o == '0);

  always_comb begin
    if (op_i == OP_SUB && a_i == b_i && !$isunknown(a_i)) begin
      AST_SUB_EQUAL_NO_BORROW: assert (c_o && dc_o && z_o) // R8
        else $error("subtract of equal operands must give C=DC=Z=1");
    end
  end

endmodule

// File: rtl/procstat_pwr_bits.sv
module procstat_pwr_bits (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic wdt_clr_i,
  input  logic sleep_i,
  input  logic wdt_to_i,
  output logic to_o,
  output logic pd_o
);

  logic to_q, pd_q;
  logic to_set_w, to_clr_w, pd_set_w, pd_clr_w, any_evt_w;

  assign to_clr_w  = wdt_to_i;
  assign to_set_w  = !wdt_to_i && (wdt_clr_i || sleep_i);
  assign pd_clr_w  = sleep_i;
  assign pd_set_w  = !sleep_i && wdt_clr_i && !wdt_to_i;
  assign any_evt_w = wdt_clr_i || sleep_i || wdt_to_i;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else begin
      if (to_clr_w)      to_q <= 1'b0;
      else if (to_set_w) to_q <= 1'b1;
      if (pd_clr_w)      pd_q <= 1'b0;
      else if (pd_set_w) pd_q <= 1'b1;
    end
  end

  assign to_o = to_q;
  assign pd_o = pd_q;

  AST_TO_ON_TIMEOUT: assert property (@(posedge clk_i) disable iff (!por_n_i)
    wdt_to_i |=> !to_o) else $error("timeout must clear TO"); // R10
  AST_PD_ON_SLEEP: assert property (@(posedge clk_i) disable iff (!por_n_i)
    sleep_i |=> !pd_o) else $error("sleep must clear PD"); // R10
  AST_CLR_LOSES_TO_TIMEOUT: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (wdt_to_i && wdt_clr_i && !sleep_i) |=> $stable(pd_o)) else $error("clear beside timeout moved PD"); // R11
  AST_PWR_QUIET: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !any_evt_w |=> ($stable(to_o) && $stable(pd_o))) else $error("power bits moved without event"); // R4

endmodule

// File: rtl/procstat_bank_map.sv
module procstat_bank_map #(
  parameter int BANK_BYTES = 128
) (
  input  logic                                irp_i,
  input  logic [1:0]                          rp_i,
  output logic [1:0]                          dir_bank_o,
  output logic [$clog2(BANK_BYTES)+1:0]       dir_base_o,
  output logic                                ind_hi_o
);

  localparam int OFF_W = $clog2(BANK_BYTES);

  assign dir_bank_o = rp_i;
  assign dir_base_o = {rp_i, {OFF_W{1'b0}}};
  assign ind_hi_o   = irp_i;

endmodule

// File: rtl/procstat_reg.sv
module procstat_reg
  import procstat_pkg::*;
#(
  parameter int DW         = 8,
  parameter int NIB        = 4,
  parameter int BANK_BYTES = 128,
  localparam int ADDR_W    = $clog2(BANK_BYTES) + 2
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              upd_z_i,
  input  logic              upd_dc_i,
  input  logic              upd_c_i,
  input  logic [2:0]        op_i,
  input  logic [DW-1:0]     opa_i,
  input  logic [DW-1:0]     opb_i,
  input  logic              rot_bit_i,
  input  logic              wdt_clr_i,
  input  logic              sleep_i,
  input  logic              wdt_to_i,
  output logic [7:0]        status_o,
  output logic [1:0]        dir_bank_o,
  output logic [ADDR_W-1:0] dir_base_o,
  output logic              ind_hi_o
);

  logic [DW-1:0] alu_res_w;
  logic          alu_z_w, alu_dc_w, alu_c_w;
  logic          to_w, pd_w;
  logic [2:0]    bank_q;
  logic          z_q, dc_q, c_q;
  logic          flag_upd_any_w;
  logic          bus_lo_ok_w;

  procstat_flag_alu #(.DW(DW), .NIB(NIB)) alu_i (
    .op_i      (alu_op_e'(op_i)),
    .a_i       (opa_i),
    .b_i       (opb_i),
    .rot_bit_i (rot_bit_i),
    .res_o     (alu_res_w),
    .z_o       (alu_z_w),
    .dc_o      (alu_dc_w),
    .c_o       (alu_c_w)
  );

  procstat_pwr_bits pwr_i (
    .clk_i     (clk_i),
    .por_n_i   (por_n_i),
    .wdt_clr_i (wdt_clr_i),
    .sleep_i   (sleep_i),
    .wdt_to_i  (wdt_to_i),
    .to_o      (to_w),
    .pd_o      (pd_w)
  );

  assign flag_upd_any_w = upd_z_i || upd_dc_i || upd_c_i;
  assign bus_lo_ok_w    = wr_en_i && !flag_upd_any_w;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      bank_q <= 3'b000;
      z_q    <= 1'b0;
      dc_q   <= 1'b0;
      c_q    <= 1'b0;
    end else begin
      if (wr_en_i) bank_q <= wr_data_i[ST_IRP:ST_RP0];
      if (upd_z_i)          z_q  <= alu_z_w;
      else if (bus_lo_ok_w) z_q  <= wr_data_i[ST_Z];
      if (upd_dc_i)         dc_q <= alu_dc_w;
      else if (bus_lo_ok_w) dc_q <= wr_data_i[ST_DC];
      if (upd_c_i)          c_q  <= alu_c_w;
      else if (bus_lo_ok_w) c_q  <= wr_data_i[ST_C];
    end
  end

  assign status_o = {bank_q, to_w, pd_w, z_q, dc_q, c_q};

  procstat_bank_map #(.BANK_BYTES(BANK_BYTES)) map_i (
    .irp_i      (bank_q[2]),
    .rp_i       (bank_q[1:0]),
    .dir_bank_o (dir_bank_o),
    .dir_base_o (dir_base_o),
    .ind_hi_o   (ind_hi_o)
  );

  AST_BANK_FROM_BUS: assert property (@(posedge clk_i) disable iff (!por_n_i)
    wr_en_i |=> status_o[7:5] == $past(wr_data_i[7:5])) else $error("bank bits not written"); // R3
  AST_CARRY_BLOCKED: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (wr_en_i && flag_upd_any_w && !upd_c_i) |=> $stable(status_o[ST_C])) else $error("bus reached carry"); // R5
  AST_FLAGS_IDLE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (!wr_en_i && !flag_upd_any_w) |=> $stable(status_o[2:0])) else $error("flags moved while idle"); // R5
  AST_ROT_CARRY: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (upd_c_i && op_i == 3'd6) |=> status_o[ST_C] == $past(rot_bit_i)) else $error("rotate carry wrong"); // R9

endmodule

// File: tb/procstat_reg_tb_top.sv
`timescale 1ns/1ps
module procstat_reg_tb_top;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       upd_z = 1'b0, upd_dc = 1'b0, upd_c = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] opa = '0, opb = '0;
  logic       rot_bit = 1'b0;
  logic       wdt_clr = 1'b0, slp = 1'b0, wdt_to = 1'b0;
  logic [7:0] status;
  logic [1:0] dir_bank;
  logic [8:0] dir_base;
  logic       ind_hi;

  int n_cmp = 0;
  int n_bad = 0;
  item_t sb_q[$];

  logic [7:0] m_st;
  logic [2:0] m_known;

  always #5 clk = ~clk;

  procstat_reg dut_i (
    .clk_i(clk), .por_n_i(por_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .upd_z_i(upd_z), .upd_dc_i(upd_dc), .upd_c_i(upd_c), .op_i(op),
    .opa_i(opa), .opb_i(opb), .rot_bit_i(rot_bit), .wdt_clr_i(wdt_clr),
    .sleep_i(slp), .wdt_to_i(wdt_to), .status_o(status), .dir_bank_o(dir_bank),
    .dir_base_o(dir_base), .ind_hi_o(ind_hi)
  );

  task automatic step(input logic we, input logic [7:0] wd, input logic uz, input logic udc,
                      input logic uc, input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                      input logic rb, input logic clr, input logic sl, input logic tmo, input string tag);
    logic [7:0] r;
    logic fz, fdc, fc, any;
    item_t it;
    @(negedge clk);
    wr_en = we; wr_data = wd; upd_z = uz; upd_dc = udc; upd_c = uc; op = o;
    opa = a; opb = b; rot_bit = rb; wdt_clr = clr; slp = sl; wdt_to = tmo;
    fdc = 1'b0; fc = 1'b0; r = a;
    case (o)
      3'd0: begin r = a + b; fc = (int'(a) + int'(b)) > 255; fdc = (int'(a[3:0]) + int'(b[3:0])) > 15; end
      3'd1: begin r = a - b; fc = (a >= b); fdc = (a[3:0] >= b[3:0]); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd6: fc = rb;
      default: r = a;
    endcase
    fz = (r == 8'h00);
    any = uz | udc | uc;
    if (we) m_st[7:5] = wd[7:5];
    if (uz) begin m_st[2] = fz; m_known[2] = 1'b1; end
    else if (we && !any) begin m_st[2] = wd[2]; m_known[2] = 1'b1; end
    if (udc) begin m_st[1] = fdc; m_known[1] = 1'b1; end
    else if (we && !any) begin m_st[1] = wd[1]; m_known[1] = 1'b1; end
    if (uc) begin m_st[0] = fc; m_known[0] = 1'b1; end
    else if (we && !any) begin m_st[0] = wd[0]; m_known[0] = 1'b1; end
    if (tmo) m_st[4] = 1'b0;
    else if (clr || sl) m_st[4] = 1'b1;
    if (sl) m_st[3] = 1'b0;
    else if (clr && !tmo) m_st[3] = 1'b1;
    it.exp = m_st; it.mask = {5'b11111, m_known}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_cmp++;
        if ((status & it.mask) !== (it.exp & it.mask)) begin
          n_bad++;
          $display("FAIL %s status actual=%02h expected=%02h mask=%02h", it.tag, status, it.exp, it.mask);
        end
        if (dir_bank !== it.exp[6:5] || dir_base !== {it.exp[6:5], 7'b0} || ind_hi !== it.exp[7]) begin
          n_bad++;
          $display("FAIL R1 bank actual=%0h/%03h/%0b expected=%0h/%03h/%0b", dir_bank, dir_base, ind_hi,
                   it.exp[6:5], {it.exp[6:5], 7'b0}, it.exp[7]);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    m_st = 8'h18; m_known = 3'b000;
    repeat (3) @(negedge clk);
    n_cmp++;
    if ((status & 8'hF8) !== 8'h18) begin
      n_bad++;
      $display("FAIL R2 in reset actual=%02h expected=18", status & 8'hF8);
    end
    por_n = 1'b1;
    idle("R2");
    // R3 R4: bus writes, power bits untouched
    step(1, 8'hFF, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R3");
    step(1, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R4");
    step(1, 8'h05, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R3");
    // R1: bank selections
    step(1, 8'h40, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R1");
    step(1, 8'h60, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R1");
    step(1, 8'h20, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R1");
    step(1, 8'h80, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R1");
    // R7: add
    step(0, 8'h00, 1,1,1, 3'd0, 8'h0F, 8'h01, 0, 0,0,0, "R7");
    step(0, 8'h00, 1,1,1, 3'd0, 8'hF0, 8'h10, 0, 0,0,0, "R7");
    step(0, 8'h00, 1,1,1, 3'd0, 8'h08, 8'h08, 0, 0,0,0, "R7");
    step(0, 8'h00, 1,1,1, 3'd0, 8'hFF, 8'h01, 0, 0,0,0, "R7");
    // R8: subtract
    step(0, 8'h00, 1,1,1, 3'd1, 8'h05, 8'h05, 0, 0,0,0, "R8");
    step(0, 8'h00, 1,1,1, 3'd1, 8'h03, 8'h05, 0, 0,0,0, "R8");
    step(0, 8'h00, 1,1,1, 3'd1, 8'h10, 8'h01, 0, 0,0,0, "R8");
    step(0, 8'h00, 1,1,1, 3'd1, 8'h00, 8'h00, 0, 0,0,0, "R8");
    // R6: logic ops, only Z updated
    step(0, 8'h00, 1,0,0, 3'd2, 8'hF0, 8'h0F, 0, 0,0,0, "R6");
    step(0, 8'h00, 1,0,0, 3'd4, 8'hAA, 8'hAA, 0, 0,0,0, "R6");
    step(0, 8'h00, 1,0,0, 3'd3, 8'h00, 8'h01, 0, 0,0,0, "R6");
    step(0, 8'h00, 1,1,1, 3'd5, 8'h00, 8'h33, 0, 0,0,0, "R6");
    // R9: rotate
    step(0, 8'h00, 0,0,1, 3'd6, 8'h80, 8'h00, 1, 0,0,0, "R9");
    step(0, 8'h00, 0,0,1, 3'd6, 8'h01, 8'h00, 0, 0,0,0, "R9");
    step(0, 8'h00, 0,0,1, 3'd6, 8'h00, 8'h00, 1, 0,0,0, "R9");
    // R5: write with flag update
    step(1, 8'hE7, 1,0,0, 3'd5, 8'h55, 8'h00, 0, 0,0,0, "R5");
    step(1, 8'h03, 0,0,1, 3'd6, 8'h00, 8'h00, 0, 0,0,0, "R5");
    step(1, 8'h07, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R5");
    // R12: clear with zero flag
    step(1, 8'hE0, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R12");
    step(1, 8'h00, 1,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R12");
    // R10: power events, with bus writes trying to touch bits 4:3
    step(0, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,1,0, "R10");
    step(1, 8'h18, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R4");
    step(0, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 1,0,0, "R10");
    step(0, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,1, "R10");
    step(1, 8'hFF, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,0,0, "R4");
    // R11: priorities
    step(0, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,1,0, "R11");
    step(0, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 1,0,1, "R11");
    step(0, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 1,1,0, "R11");
    step(0, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 1,0,0, "R11");
    step(0, 8'h00, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 1,1,1, "R11");
    idle("R4");
    // R2: power-on overrides events
    step(1, 8'hE0, 0,0,0, 3'd5, 8'h00, 8'h00, 0, 0,1,1, "R11");
    @(negedge clk);
    wdt_to = 1'b1; slp = 1'b1;
    por_n = 1'b0;
    #1;
    n_cmp++;
    if ((status & 8'hF8) !== 8'h18) begin
      n_bad++;
      $display("FAIL R2 power-on actual=%02h expected=18", status & 8'hF8);
    end
    sb_q.delete();
    @(negedge clk);
    wdt_to = 1'b0; slp = 1'b0; wr_en = 1'b0;
    por_n = 1'b1;
    m_st = 8'h18; m_known = 3'b000;
    idle("R2");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule